// File: doc/BRIEF.md
# Four-Level Nested Interrupt Controller

This block sits beside a small 8-bit CPU core and decides which of six interrupt sources is serviced next. The six sources are two external lines, three timers and one serial port. Each source is given one of four priority levels by one bit in each of two priority registers. An enable register holds a global enable bit and one enable bit per source. Software reaches all three registers through a byte-wide special-function-register port.

Every cycle the controller finds the highest-level pending source that is enabled. Among sources at the same level, a fixed polling order decides. The winner is compared with the levels already in service. If the winner's level is above all of them, a request and a vector address are presented to the CPU. An acknowledge marks the winner's level as in service and clears the source flag when that source type is cleared in hardware. A return strobe retires the highest level in service. An interrupted lower-level handler therefore resumes once the nested handler returns.

The timer, serial and external inputs arrive as raw request lines. The external lines can each be set to edge or level triggering.

Top module: `irq_nest_ctrl`

## Requirements
- R1: The level of source x is the 2-bit value {high-priority bit x, low-priority bit x}, with 0 the lowest and 3 the highest. A pending source at a higher level wins over any source at a lower level, whatever their polling positions.
- R2: Among pending sources at the same level, the winner is the first in this polling order: external 0 (index 0), timer 0 (index 1), external 1 (index 2), timer 1 (index 3), serial (index 4), timer 2 (index 5). Source index x uses bit x of the enable and priority registers.
- R3: The vector address is 03h + 8 × index, giving 03h, 0Bh, 13h, 1Bh, 23h and 2Bh in polling order.
- R4: The enable register is at address A8h, with bit 7 the global enable and bits 5..0 the source enables. Bit 6 reads 0. The low-priority register is at B8h and the high-priority register at B7h, each with bits 5..0 used and bits 7..6 reading 0. Any other address reads 00h, and a write to it changes nothing.
- R5: While the global enable is 0, no request is raised. While it is 1, a source is only taken if its own enable bit is 1. A flag that is set while its source is disabled stays pending.
- R6: A pending source is not presented while a level equal to or above its own is in service.
- R7: A source at a level strictly above every level in service is presented even while a handler runs. Each return strobe retires only the highest level in service, so lower levels stay blocked or in service until their own return.
- R8: An acknowledge that arrives while the request is high marks the presented level as in service, and the request output is low in the cycle that follows.
- R9: A pulse on a timer 0 or timer 1 overflow input sets its flag, and acknowledge of that source clears it. A new pulse in the acknowledge cycle wins, so the flag stays set.
- R10: In edge mode (mode bit 1), a rising edge on an external line sets its flag, and acknowledge clears it. In level mode (mode bit 0), the flag follows the line and acknowledge does not clear it.
- R11: The serial request is the OR of its receive and transmit inputs. The timer 2 request is the OR of its overflow and external inputs. Acknowledge clears neither, and each stays requested while an input is high.
- R12: After reset all three registers read 00h, the request output is low and no level is in service.
- R13: A flag-setting input that is high for the clock edge before edge k, with the path otherwise free, gives the request output high after edge k+1, not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | 8 | Register address for read and write |
| sfr_wr | input | 1 | Write strobe |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data for sfr_addr (combinational) |
| ext_line | input | 2 | Raw external request lines, bit 0 = external 0 |
| ext_edge_mode | input | 2 | 1 = edge triggered, 0 = level triggered, per external line |
| t0_ovf | input | 1 | Timer 0 overflow pulse |
| t1_ovf | input | 1 | Timer 1 overflow pulse |
| ser_rx | input | 1 | Serial receive flag |
| ser_tx | input | 1 | Serial transmit flag |
| t2_ovf | input | 1 | Timer 2 overflow flag |
| t2_ext | input | 1 | Timer 2 external flag |
| irq_req | output | 1 | Interrupt request to the CPU |
| irq_vec | output | 8 | Vector address of the presented source |
| irq_ack | input | 1 | CPU takes the presented interrupt |
| irq_ret | input | 1 | CPU returns from the current handler |

## Verification
Two events can fall in the same clock cycle. The acknowledge that clears the timer 0 flag in hardware can coincide with a new timer 0 overflow pulse. The bench drives both in the same cycle. It then checks that the request is low in the following cycle, and that after a return the same vector is presented again, because the new pulse must win over the clear. A scoreboard process plays the CPU: it compares each presented vector against the queue of expected vectors. Any request that arrives while the queue is empty counts as a nesting or blocking error.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int NSRC = 6;
   localparam int NLVL = 4;
   localparam int LVLW = $clog2(NLVL);
   localparam int IDXW = $clog2(NSRC);
   localparam int NWOR = NSRC - 4;

   typedef logic [LVLW-1:0] lvl_t;
   typedef logic [IDXW-1:0] sidx_t;

   typedef enum logic [1:0] {
      SRC_EXT      = 2'd0,
      SRC_TMR      = 2'd1,
      SRC_WIRED_OR = 2'd2
   } src_kind_e;

   // sources 0..3 alternate external / timer, the remaining ones are wired-OR pairs
   function automatic src_kind_e kind_of(input int i);
      if (i >= 4) return SRC_WIRED_OR;
      return (i % 2 == 0) ? SRC_EXT : SRC_TMR;
   endfunction

   function automatic lvl_t top_level(input logic [NLVL-1:0] m);
      lvl_t t;
      t = '0;
      for (int l = 0; l < NLVL; l++) begin
         if (m[l]) t = lvl_t'(l);
      end
      return t;
   endfunction
endpackage

// File: rtl/irq_sfr_regs.sv
module irq_sfr_regs
   import irq_nest_pkg::*;
#(
   parameter int                AW   = 8,
   parameter int                DW   = 8,
   parameter logic [AW-1:0]     A_EN = 8'hA8,
   parameter logic [AW-1:0]     A_PL = 8'hB8,
   parameter logic [AW-1:0]     A_PH = 8'hB7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   addr,
   input  logic            wr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   output logic            ea,
   output logic [NSRC-1:0] en,
   output logic [NSRC-1:0] pl,
   output logic [NSRC-1:0] ph
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int EA_BIT = DW - 1;

   logic            ea_q;
   logic [NSRC-1:0] en_q, pl_q, ph_q;
   logic            unused_wbits;

   assign unused_wbits = ^wdata[DW-2:NSRC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q <= 1'b0;
         en_q <= '0;
         pl_q <= '0;
         ph_q <= '0;
      end else if (wr) begin
         if (addr == A_EN) begin
            ea_q <= wdata[EA_BIT];
            en_q <= wdata[NSRC-1:0];
         end
         if (addr == A_PL) pl_q <= wdata[NSRC-1:0];
         if (addr == A_PH) ph_q <= wdata[NSRC-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_EN) begin
         rdata[NSRC-1:0] = en_q;
         rdata[EA_BIT]   = ea_q;
      end else if (addr == A_PL) begin
         rdata[NSRC-1:0] = pl_q;
      end else if (addr == A_PH) begin
         rdata[NSRC-1:0] = ph_q;
      end
   end

   assign ea = ea_q;
   assign en = en_q;
   assign pl = pl_q;
   assign ph = ph_q;
endmodule

// File: rtl/irq_src_flags.sv
module irq_src_flags
   import irq_nest_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_line,
   input  logic [1:0]        ext_edge,
   input  logic [1:0]        tmr_ovf,
   input  logic [2*NWOR-1:0] wor_in,
   input  logic              clr,
   input  sidx_t             clr_idx,
   output logic [NSRC-1:0]   flag
);
   timeunit 1ns;
   timeprecision 100ps;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam src_kind_e K = kind_of(i);
      logic f_q;
      logic clr_here;

      assign clr_here = clr && (clr_idx == sidx_t'(i));
      assign flag[i]  = f_q;

      if (K == SRC_EXT) begin : g_ext
         localparam int E = i / 2;
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= 1'b0;
               f_q    <= 1'b0;
            end else begin
               prev_q <= ext_line[E];
               if (ext_edge[E])
                  f_q <= (ext_line[E] & ~prev_q) | (f_q & ~clr_here);
               else
                  f_q <= ext_line[E];
            end
         end
      end else if (K == SRC_TMR) begin : g_tmr
         localparam int T = i / 2;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= tmr_ovf[T] | (f_q & ~clr_here);
         end
      end else begin : g_wor
         localparam int W = i - 4;
         logic unused_clr;
         assign unused_clr = clr_here;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) f_q <= 1'b0;
            else        f_q <= |wor_in[2*W +: 2];
         end
      end
   end
endmodule

// File: rtl/irq_pick.sv
module irq_pick
   import irq_nest_pkg::*;
(
   input  logic [NSRC-1:0] flag,
   input  logic [NSRC-1:0] en,
   input  logic            ea,
   input  logic [NSRC-1:0] pl,
   input  logic [NSRC-1:0] ph,
   input  logic            busy,
   input  lvl_t            busy_lvl,
   output logic            take,
   output sidx_t           win_idx,
   output lvl_t            win_lvl
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [NSRC-1:0] live;
   logic            found;
   lvl_t            best;
   sidx_t           bi;

   assign live = flag & en & {NSRC{ea}};

   // descending scan: on equal level the lower index overwrites, giving polling order
   always_comb begin
      found = 1'b0;
      best  = '0;
      bi    = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (live[i] && (!found || {ph[i], pl[i]} >= best)) begin
            found = 1'b1;
            best  = {ph[i], pl[i]};
            bi    = sidx_t'(i);
         end
      end
   end

   assign take    = found && (!busy || best > busy_lvl);
   assign win_idx = bi;
   assign win_lvl = best;
endmodule

// File: rtl/irq_level_stack.sv
module irq_level_stack
   import irq_nest_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push,
   input  lvl_t            push_lvl,
   input  logic            pop,
   output logic [NLVL-1:0] mask,
   output lvl_t            top_lvl,
   output logic            any
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [NLVL-1:0] m_q, m_nxt;

   assign any     = |m_q;
   assign top_lvl = top_level(m_q);
   assign mask    = m_q;

   always_comb begin
      m_nxt = m_q;
      if (pop && any) m_nxt[top_lvl] = 1'b0;
      if (push)       m_nxt[push_lvl] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_q <= '0;
      else        m_q <= m_nxt;
   end
endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
   import irq_nest_pkg::*;
#(
   parameter int                 SFR_AW   = 8,
   parameter int                 SFR_DW   = 8,
   parameter logic [SFR_AW-1:0]  ADDR_EN  = 8'hA8,
   parameter logic [SFR_AW-1:0]  ADDR_PL  = 8'hB8,
   parameter logic [SFR_AW-1:0]  ADDR_PH  = 8'hB7,
   parameter int                 VEC_W    = 8,
   parameter int                 VEC_BASE = 3,
   parameter int                 VEC_STEP = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic              sfr_wr,
   input  logic [SFR_DW-1:0] sfr_wdata,
   output logic [SFR_DW-1:0] sfr_rdata,
   input  logic [1:0]        ext_line,
   input  logic [1:0]        ext_edge_mode,
   input  logic              t0_ovf,
   input  logic              t1_ovf,
   input  logic              ser_rx,
   input  logic              ser_tx,
   input  logic              t2_ovf,
   input  logic              t2_ext,
   output logic              irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   input  logic              irq_ack,
   input  logic              irq_ret
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int VEC_TOP = VEC_BASE + VEC_STEP * (NSRC - 1);

   if (SFR_DW < NSRC + 2) begin : g_bad_dw
      $error("SFR_DW too narrow for enables plus global bit");
   end
   if (ADDR_EN == ADDR_PL || ADDR_EN == ADDR_PH || ADDR_PL == ADDR_PH) begin : g_bad_addr
      $error("register addresses must differ");
   end
   if (VEC_TOP >= (1 << VEC_W) || VEC_STEP < 1) begin : g_bad_vec
      $error("vector table does not fit VEC_W");
   end

   logic            sfr_ea;
   logic [NSRC-1:0] sfr_en, sfr_pl, sfr_ph;
   logic [NSRC-1:0] src_flag;
   logic [NLVL-1:0] isr_mask;
   lvl_t            isr_top;
   logic            isr_any;
   logic            take;
   sidx_t           win_idx;
   lvl_t            win_lvl;
   logic            req_q;
   sidx_t           idx_q;
   lvl_t            lvl_q;
   logic            ack_hit;

   assign ack_hit = irq_ack & req_q;

   irq_sfr_regs #(
      .AW(SFR_AW), .DW(SFR_DW), .A_EN(ADDR_EN), .A_PL(ADDR_PL), .A_PH(ADDR_PH)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(sfr_addr), .wr(sfr_wr), .wdata(sfr_wdata),
      .rdata(sfr_rdata), .ea(sfr_ea), .en(sfr_en), .pl(sfr_pl), .ph(sfr_ph)
   );

   irq_src_flags u_flags (
      .clk(clk), .rst_n(rst_n), .ext_line(ext_line), .ext_edge(ext_edge_mode),
      .tmr_ovf({t1_ovf, t0_ovf}), .wor_in({t2_ext, t2_ovf, ser_tx, ser_rx}),
      .clr(ack_hit), .clr_idx(idx_q), .flag(src_flag)
   );

   irq_pick u_pick (
      .flag(src_flag), .en(sfr_en), .ea(sfr_ea), .pl(sfr_pl), .ph(sfr_ph),
      .busy(isr_any), .busy_lvl(isr_top), .take(take), .win_idx(win_idx),
      .win_lvl(win_lvl)
   );

   irq_level_stack u_stack (
      .clk(clk), .rst_n(rst_n), .push(ack_hit), .push_lvl(lvl_q), .pop(irq_ret),
      .mask(isr_mask), .top_lvl(isr_top), .any(isr_any)
   );

   // presentation register: forced low for one cycle after an acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
         idx_q <= '0;
         lvl_q <= '0;
      end else begin
         req_q <= take & ~ack_hit;
         if (take && !ack_hit) begin
            idx_q <= win_idx;
            lvl_q <= win_lvl;
         end
      end
   end

   assign irq_req = req_q;
   assign irq_vec = VEC_W'(VEC_BASE + VEC_STEP * int'(idx_q));
endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk
   import irq_nest_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            irq_ack,
   input logic            irq_ret,
   input logic            t0_ovf,
   input logic            ea,
   input logic [NLVL-1:0] isr_mask,
   input lvl_t            lvl_q,
   input sidx_t           idx_q,
   input logic [NSRC-1:0] flags
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam sidx_t T0_IDX = sidx_t'(1);

   // R5
   a_r5_global_off: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ea) |-> !irq_req);

   // R6
   a_r6_only_above: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> (isr_mask == '0 || lvl_q > top_level(isr_mask)));

   // R8
   a_r8_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req);

   // R8
   a_r8_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> isr_mask[$past(lvl_q)]);

   // R7
   a_r7_ret_one_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ret && !(irq_ack && irq_req) && isr_mask != '0
      |=> $countones(isr_mask) == $countones($past(isr_mask)) - 1);

   // R9
   a_r9_t0_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && idx_q == T0_IDX && !t0_ovf |=> !flags[1]);
endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
   .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_ack(irq_ack),
   .irq_ret(irq_ret), .t0_ovf(t0_ovf), .ea(sfr_ea), .isr_mask(isr_mask),
   .lvl_q(lvl_q), .idx_q(idx_q), .flags(src_flag)
);

// File: tb/sim_irq_nest_ctrl.sv
module sim_irq_nest_ctrl;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] sfr_addr = '0;
   logic       sfr_wr = 1'b0;
   logic [7:0] sfr_wdata = '0;
   logic [7:0] sfr_rdata;
   logic [1:0] ext_line = '0;
   logic [1:0] ext_edge_mode = '0;
   logic       t0_ovf = 1'b0, t1_ovf = 1'b0;
   logic       ser_rx = 1'b0, ser_tx = 1'b0;
   logic       t2_ovf = 1'b0, t2_ext = 1'b0;
   logic       irq_req;
   logic [7:0] irq_vec;
   logic       irq_ack = 1'b0;
   logic       irq_ret = 1'b0;

   int         total = 0;
   int         bad = 0;
   logic [7:0] exp_q[$];
   logic       mon_on = 1'b0;
   logic       mon_acked = 1'b0;

   always #2.5 clk = ~clk;

   irq_nest_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
      .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .ext_line(ext_line),
      .ext_edge_mode(ext_edge_mode), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
      .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
      .irq_req(irq_req), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
   );

   task automatic check(input bit ok, input string r, input string what,
                        input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, expv);
      end
   endtask

   // scoreboard monitor acting as the CPU
   always @(negedge clk) begin
      if (mon_on) begin
         if (mon_acked) begin
            irq_ack   = 1'b0;
            mon_acked = 1'b0;
         end else if (irq_req) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R6", "request with nothing expected", int'(irq_vec), 0);
            end else begin
               logic [7:0] e;
               e = exp_q.pop_front();
               check(irq_vec == e, "R3", "vector order", int'(irq_vec), int'(e));
            end
            irq_ack   = 1'b1;
            mon_acked = 1'b1;
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
      @(negedge clk);
      sfr_wr = 1'b0;
   endtask

   task automatic sfr_expect(input logic [7:0] a, input logic [7:0] e, input string r);
      @(negedge clk);
      sfr_addr = a;
      #1;
      check(sfr_rdata == e, r, "register read", int'(sfr_rdata), int'(e));
   endtask

   task automatic ret_pulse();
      @(negedge clk); irq_ret = 1'b1;
      @(negedge clk); irq_ret = 1'b0;
   endtask

   task automatic drain();
      while (exp_q.size() != 0) @(negedge clk);
      tick(2);
   endtask

   task automatic expect_quiet(input int n, input string r);
      bit seen;
      seen = 1'b0;
      repeat (n) begin
         @(negedge clk);
         if (irq_req) seen = 1'b1;
      end
      check(!seen, r, "request stays low", int'(seen), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R12 reset state
      check(irq_req == 1'b0, "R12", "request after reset", int'(irq_req), 0);
      sfr_expect(8'hA8, 8'h00, "R12");
      sfr_expect(8'hB7, 8'h00, "R12");
      sfr_expect(8'hB8, 8'h00, "R12");

      // R4 register map
      sfr_write(8'hA8, 8'hFF); sfr_expect(8'hA8, 8'hBF, "R4");
      sfr_write(8'hB8, 8'hFF); sfr_expect(8'hB8, 8'h3F, "R4");
      sfr_write(8'hB7, 8'hC5); sfr_expect(8'hB7, 8'h05, "R4");
      sfr_write(8'hB9, 8'hFF); sfr_expect(8'hB9, 8'h00, "R4");
      sfr_expect(8'hB8, 8'h3F, "R4");
      sfr_write(8'hB8, 8'h00); sfr_write(8'hB7, 8'h00);

      // R2 polling order, R9/R10/R11 clear rules, equal level blocked (R6)
      mon_on = 1'b1;
      ext_edge_mode = 2'b11;
      exp_q.push_back(8'h03);
      @(negedge clk);
      ext_line = 2'b11; t0_ovf = 1'b1; t1_ovf = 1'b1; ser_tx = 1'b1; t2_ext = 1'b1;
      @(negedge clk);
      t0_ovf = 1'b0; t1_ovf = 1'b0;
      drain();
      exp_q.push_back(8'h0B); ret_pulse(); drain();
      exp_q.push_back(8'h13); ret_pulse(); drain();
      exp_q.push_back(8'h1B); ret_pulse(); drain();
      exp_q.push_back(8'h23); ret_pulse(); drain();
      ser_tx = 1'b0; tick(2);
      exp_q.push_back(8'h2B); ret_pulse(); drain();
      t2_ext = 1'b0; tick(2);
      ret_pulse();
      expect_quiet(10, "R9");
      ext_line = 2'b00;
      tick(2);

      // R10 level mode retriggers after return
      ext_edge_mode = 2'b00;
      exp_q.push_back(8'h03);
      ext_line[0] = 1'b1;
      drain();
      exp_q.push_back(8'h03);
      ret_pulse(); drain();
      check(exp_q.size() == 0, "R10", "level source re-presented", exp_q.size(), 0);
      ext_line[0] = 1'b0; tick(2);
      ret_pulse();
      expect_quiet(8, "R10");

      // R1/R7 nesting: t0 level 3, t1 level 2, t2 level 1, ext0 level 0
      ext_edge_mode = 2'b11;
      sfr_write(8'hB8, 8'h22);
      sfr_write(8'hB7, 8'h0A);
      exp_q.push_back(8'h03);
      ext_line[0] = 1'b1;
      drain();
      exp_q.push_back(8'h1B);
      @(negedge clk); t1_ovf = 1'b1; @(negedge clk); t1_ovf = 1'b0;
      drain();
      exp_q.push_back(8'h0B);
      @(negedge clk); t0_ovf = 1'b1; @(negedge clk); t0_ovf = 1'b0;
      drain();
      t2_ovf = 1'b1;
      expect_quiet(8, "R6");
      ret_pulse();
      expect_quiet(6, "R7");
      exp_q.push_back(8'h2B);
      ret_pulse(); drain();
      t2_ovf = 1'b0; tick(2);
      ret_pulse(); ret_pulse();
      expect_quiet(6, "R7");
      ext_line[0] = 1'b0; tick(2);

      // R1 higher level beats earlier polling position
      exp_q.push_back(8'h2B);
      @(negedge clk); ext_line[0] = 1'b1; t2_ovf = 1'b1;
      drain();
      t2_ovf = 1'b0; tick(2);
      exp_q.push_back(8'h03);
      ret_pulse(); drain();
      ret_pulse();
      ext_line[0] = 1'b0;
      sfr_write(8'hB8, 8'h00); sfr_write(8'hB7, 8'h00);
      tick(2);

      // R5 global and individual enables
      sfr_write(8'hA8, 8'h3F);
      @(negedge clk); t0_ovf = 1'b1; @(negedge clk); t0_ovf = 1'b0;
      expect_quiet(10, "R5");
      sfr_write(8'hA8, 8'hBD);
      expect_quiet(10, "R5");
      exp_q.push_back(8'h0B);
      sfr_write(8'hA8, 8'hBF);
      drain();
      ret_pulse();
      tick(3);
      mon_on = 1'b0;

      // R13 latency and R8 acknowledge gap
      @(negedge clk); t1_ovf = 1'b1;
      @(negedge clk); t1_ovf = 1'b0;
      check(irq_req == 1'b0, "R13", "request one edge after flag input", int'(irq_req), 0);
      @(negedge clk);
      check(irq_req == 1'b1 && irq_vec == 8'h1B, "R13", "request two edges after flag input",
            int'({irq_req, irq_vec}), int'({1'b1, 8'h1B}));
      irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      check(irq_req == 1'b0, "R8", "request low after acknowledge", int'(irq_req), 0);
      tick(3);
      ret_pulse();
      tick(4);
      check(irq_req == 1'b0, "R9", "timer 1 flag cleared by acknowledge", int'(irq_req), 0);

      // R9 new overflow in the acknowledge cycle wins over the clear
      @(negedge clk); t0_ovf = 1'b1;
      @(negedge clk); t0_ovf = 1'b0;
      @(negedge clk);
      check(irq_req == 1'b1 && irq_vec == 8'h0B, "R9", "timer 0 presented",
            int'({irq_req, irq_vec}), int'({1'b1, 8'h0B}));
      irq_ack = 1'b1; t0_ovf = 1'b1;
      @(negedge clk); irq_ack = 1'b0; t0_ovf = 1'b0;
      check(irq_req == 1'b0, "R8", "request low after acknowledge", int'(irq_req), 0);
      ret_pulse();
      @(negedge clk);
      check(irq_req == 1'b1 && irq_vec == 8'h0B, "R9", "set wins over clear",
            int'({irq_req, irq_vec}), int'({1'b1, 8'h0B}));
      irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      ret_pulse();
      tick(4);
      check(irq_req == 1'b0, "R9", "flag cleared after second acknowledge", int'(irq_req), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule